// File: doc/BRIEF.md
# Wrapping Burst Beat Sequencer

This block sequences the data beats of a four-beat memory burst. Each beat carries one double word. On an accepted request it always issues a full burst in critical-word-first order. The first beat is the requested starting double-word offset, and the index then wraps modulo four. For each beat it marks whether the beat carries data for the requested transfer. Beats that fall outside a shorter transfer are still sequenced, but they are disabled.

A memory controller front end uses it to steer its data queues and to gate write strobes. A disabled write beat presents an all-zero strobe, so it does not change memory contents. A request that pairs a transfer size with a starting offset the burst cannot hold is refused. The block then raises a one-cycle error and issues no beats.

Top module: `burst_beat_seq`

## Requirements
- R1: While `rst_ni` is low, and after it is released with no request, `beat_valid_o`, `beat_en_o`, `done_o`, `err_o` and `busy_o` are 0 and `wstrb_o` is all zeros.
- R2: The beat index of the k-th beat (k = 0..3) of a burst is (start offset + k) mod 4.
- R3: When `start_i` is high at a rising edge while `busy_o` is low and the request is legal, exactly four beats follow. One beat appears per cycle, starting in the cycle after that edge, with `beat_valid_o` high, and `busy_o` is high for those four cycles.
- R4: `done_o` is high only together with the fourth beat of a burst. In the cycle after `done_o`, `beat_valid_o` is low unless a new burst was accepted.
- R5: `size_i` code 1, 2, 3 or 4 requests that many double words. Beats k < size have `beat_en_o` = 1 and the remaining beats have `beat_en_o` = 0.
- R6: A request is legal when its size code is 0 to 4 and the offset plus the double-word count does not exceed 4. This gives offsets 0..3 for one double word, 0..2 for two, 0..1 for three and only 0 for four. Size code 0 counts as one, and codes 5 to 7 are never legal. An illegal request sets `err_o` for exactly the cycle after the edge and produces no beat.
- R7: On a write request (`write_i` = 1), `wstrb_o` is all ones on an enabled beat and all zeros on a disabled beat. On a read request `wstrb_o` stays all zeros.
- R8: `start_i` and the request inputs are ignored while `busy_o` is high. The burst in progress keeps its order and enables.
- R9: Size code 0 (a transfer narrower than a double word) is legal at any offset and enables only the first beat.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Request strobe, accepted when not busy |
| offset_i | input | 2 | Starting double-word offset |
| size_i | input | 3 | Transfer size code (0 = sub-double-word, 1..4 = double words) |
| write_i | input | 1 | 1 = write request, 0 = read |
| busy_o | output | 1 | A burst is in progress |
| beat_valid_o | output | 1 | A beat is presented this cycle |
| beat_idx_o | output | 2 | Double-word index of the current beat |
| beat_en_o | output | 1 | The current beat carries transfer data |
| wstrb_o | output | DW_BYTES | Byte write strobes of the current beat |
| done_o | output | 1 | Last beat of the burst |
| err_o | output | 1 | Refused request, one-cycle pulse |

## Verification
Directed requests sweep every offset for each size code. Legal pairings are told apart from refused ones at the exact boundaries: two double words at offset 3, three at offset 2, four at offset 1, and the reserved codes. Reads and writes of the same shape show that strobes depend on direction as well as on beat enable. One burst holds `start_i` high with changed inputs to show that a running burst cannot be redirected. A seeded random stream of several hundred requests, with random gaps, mixes all of these and is compared beat by beat against the order and mask the bench computes.

// File: rtl/burst_seq_pkg.sv
package burst_seq_pkg;
  localparam int unsigned BURST_BEATS = 4;
  localparam int unsigned IDX_W       = $clog2(BURST_BEATS);
  localparam int unsigned CNT_W       = IDX_W + 1;

  localparam logic [2:0] SZ_SUB   = 3'd0;
  localparam logic [2:0] SZ_ONE   = 3'd1;
  localparam logic [2:0] SZ_TWO   = 3'd2;
  localparam logic [2:0] SZ_THREE = 3'd3;
  localparam logic [2:0] SZ_FOUR  = 3'd4;

  typedef struct packed {
    logic             wr;
    logic [IDX_W-1:0] base;
    logic [CNT_W-1:0] nvalid;
  } burst_req_t;
endpackage

// File: rtl/burst_req_check.sv
module burst_req_check
  import burst_seq_pkg::*;
(
  input  logic [IDX_W-1:0] offset_i,
  input  logic [2:0]       size_i,
  output logic             legal_o,
  output logic [CNT_W-1:0] nvalid_o
);
  logic             known;
  logic [CNT_W:0]   span;

  always_comb begin
    known    = 1'b1;
    nvalid_o = '0;
    unique case (size_i)
      SZ_SUB:   nvalid_o = CNT_W'(1);
      SZ_ONE:   nvalid_o = CNT_W'(1);
      SZ_TWO:   nvalid_o = CNT_W'(2);
      SZ_THREE: nvalid_o = CNT_W'(3);
      SZ_FOUR:  nvalid_o = CNT_W'(4);
      default:  known    = 1'b0;
    endcase
  end

  assign span    = (CNT_W+1)'(offset_i) + (CNT_W+1)'(nvalid_o);
  // sub-double-word fits in any beat; otherwise the transfer must not wrap
  assign legal_o = known && (span <= (CNT_W+1)'(BURST_BEATS));
endmodule

// File: rtl/burst_beat_ctr.sv
module burst_beat_ctr
  import burst_seq_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  burst_req_t       req_i,
  output logic             active_o,
  output logic             last_o,
  output logic [IDX_W-1:0] cnt_o,
  output burst_req_t       req_o
);
  logic [IDX_W-1:0] cnt_q;
  logic             active_q;
  burst_req_t       req_q;

  assign last_o = active_q && (cnt_q == IDX_W'(BURST_BEATS-1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      active_q <= 1'b0;
      cnt_q    <= '0;
      req_q    <= '0;
    end else if (load_i) begin
      active_q <= 1'b1;
      cnt_q    <= '0;
      req_q    <= req_i;
    end else if (active_q) begin
      if (last_o) active_q <= 1'b0;
      cnt_q <= cnt_q + IDX_W'(1);
    end
  end

  assign active_o = active_q;
  assign cnt_o    = cnt_q;
  assign req_o    = req_q;
endmodule

// File: rtl/burst_beat_mask.sv
module burst_beat_mask
  import burst_seq_pkg::*;
#(
  parameter int unsigned DW_BYTES = 8
) (
  input  logic                active_i,
  input  logic [IDX_W-1:0]    cnt_i,
  input  burst_req_t          req_i,
  output logic [IDX_W-1:0]    idx_o,
  output logic                en_o,
  output logic [DW_BYTES-1:0] wstrb_o
);
  // critical word first, modulo burst length
  assign idx_o = req_i.base + cnt_i;
  assign en_o  = active_i && (CNT_W'(cnt_i) < req_i.nvalid);

  for (genvar b = 0; b < DW_BYTES; b++) begin : g_strb
    assign wstrb_o[b] = en_o & req_i.wr;
  end
endmodule

// File: rtl/burst_beat_seq.sv
module burst_beat_seq
  import burst_seq_pkg::*;
#(
  parameter int unsigned DW_BYTES = 8
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                start_i,
  input  logic [1:0]          offset_i,
  input  logic [2:0]          size_i,
  input  logic                write_i,
  output logic                busy_o,
  output logic                beat_valid_o,
  output logic [1:0]          beat_idx_o,
  output logic                beat_en_o,
  output logic [DW_BYTES-1:0] wstrb_o,
  output logic                done_o,
  output logic                err_o
);
  logic             legal;
  logic [CNT_W-1:0] nvalid;
  logic             accept;
  logic             active;
  logic             last;
  logic [IDX_W-1:0] cnt;
  burst_req_t       req_new;
  burst_req_t       req_cur;
  logic             err_q;

  burst_req_check u_check (
    .offset_i (offset_i),
    .size_i   (size_i),
    .legal_o  (legal),
    .nvalid_o (nvalid)
  );

  assign accept  = start_i && !active;
  assign req_new = '{wr: write_i, base: offset_i, nvalid: nvalid};

  burst_beat_ctr u_ctr (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .load_i   (accept && legal),
    .req_i    (req_new),
    .active_o (active),
    .last_o   (last),
    .cnt_o    (cnt),
    .req_o    (req_cur)
  );

  burst_beat_mask #(.DW_BYTES(DW_BYTES)) u_mask (
    .active_i (active),
    .cnt_i    (cnt),
    .req_i    (req_cur),
    .idx_o    (beat_idx_o),
    .en_o     (beat_en_o),
    .wstrb_o  (wstrb_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) err_q <= 1'b0;
    else         err_q <= accept && !legal;
  end

  assign busy_o       = active;
  assign beat_valid_o = active;
  assign done_o       = last;
  assign err_o        = err_q;
endmodule

// File: rtl/burst_beat_seq_chk.sv
module burst_beat_seq_chk #(
  parameter int unsigned DW_BYTES = 8
) (
  input logic                clk_i,
  input logic                rst_ni,
  input logic                start_i,
  input logic                busy_o,
  input logic                beat_valid_o,
  input logic [1:0]          beat_idx_o,
  input logic                beat_en_o,
  input logic [DW_BYTES-1:0] wstrb_o,
  input logic                done_o,
  input logic                err_o
);
  // R2
  idx_wrap_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    beat_valid_o && !done_o |=> beat_idx_o == 2'($past(beat_idx_o) + 2'd1));
  // R3
  burst_needs_start_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(beat_valid_o) |-> $past(start_i && !busy_o));
  // R3
  burst_continues_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    beat_valid_o && !done_o |=> beat_valid_o);
  // R4
  done_on_beat_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> beat_valid_o);
  // R4
  done_then_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !beat_valid_o);
  // R5
  en_within_beat_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    beat_en_o |-> beat_valid_o);
  // R5
  en_monotone_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    beat_valid_o && !beat_en_o && !done_o |=> !beat_en_o);
  // R6
  err_no_beat_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_o |-> !beat_valid_o);
  // R6
  err_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_o |=> !beat_valid_o);
  // R7
  strobe_gated_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wstrb_o != '0) |-> beat_en_o && (wstrb_o == '1));
endmodule

bind burst_beat_seq burst_beat_seq_chk #(.DW_BYTES(DW_BYTES)) u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .start_i      (start_i),
  .busy_o       (busy_o),
  .beat_valid_o (beat_valid_o),
  .beat_idx_o   (beat_idx_o),
  .beat_en_o    (beat_en_o),
  .wstrb_o      (wstrb_o),
  .done_o       (done_o),
  .err_o        (err_o)
);

// File: tb/burst_beat_seq_bench.sv
module burst_beat_seq_bench;
  localparam int CLK_PERIOD = 10;
  localparam int DW_BYTES   = 8;

  logic                clk_i = 1'b0;
  logic                rst_ni = 1'b0;
  logic                start_i = 1'b0;
  logic [1:0]          offset_i = '0;
  logic [2:0]          size_i = '0;
  logic                write_i = 1'b0;
  logic                busy_o, beat_valid_o, beat_en_o, done_o, err_o;
  logic [1:0]          beat_idx_o;
  logic [DW_BYTES-1:0] wstrb_o;

  int n_chk = 0;
  int n_fail = 0;

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  burst_beat_seq #(.DW_BYTES(DW_BYTES)) u_burst_beat_seq (
    .clk_i, .rst_ni, .start_i, .offset_i, .size_i, .write_i,
    .busy_o, .beat_valid_o, .beat_idx_o, .beat_en_o, .wstrb_o, .done_o, .err_o
  );

  function automatic int dw_count(input logic [2:0] sz);
    return (sz == 3'd0) ? 1 : int'(sz);
  endfunction

  function automatic bit is_legal(input logic [1:0] off, input logic [2:0] sz);
    return (sz <= 3'd4) && (int'(off) + dw_count(sz) <= 4);
  endfunction

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic chk_idle(input string tag);
    chk(beat_valid_o == 0, tag, beat_valid_o, 0);
    chk(busy_o == 0, tag, busy_o, 0);
    chk(wstrb_o == '0, tag, wstrb_o, 0);
  endtask

  // entered and left at a falling edge
  task automatic run_req(input logic [1:0] off, input logic [2:0] sz, input bit wr,
                         input bit hold);
    bit legal = is_legal(off, sz);
    int n = dw_count(sz);
    start_i = 1'b1; offset_i = off; size_i = sz; write_i = wr;
    @(negedge clk_i);
    if (hold) begin
      offset_i = off + 2'd1; size_i = 3'd7; write_i = ~wr;   // R8 must be ignored
    end else begin
      start_i = 1'b0;
    end
    if (legal) begin
      for (int k = 0; k < 4; k++) begin
        logic [1:0] e_idx = 2'(int'(off) + k);
        bit e_en = (k < n);
        logic [DW_BYTES-1:0] e_strb = (e_en && wr) ? '1 : '0;
        chk(beat_valid_o == 1 && busy_o == 1, "R3 beat present", beat_valid_o, 1);
        chk(beat_idx_o == e_idx, "R2 beat index", beat_idx_o, e_idx);
        chk(beat_en_o == e_en, (sz == 0) ? "R9 sub-dw enable" : "R5 beat enable", beat_en_o, e_en);
        chk(wstrb_o == e_strb, "R7 write strobe", wstrb_o, e_strb);
        chk(done_o == (k == 3), "R4 done", done_o, (k == 3));
        chk(err_o == 0, "R6 no err on legal", err_o, 0);
        if (k == 3) start_i = 1'b0;
        @(negedge clk_i);
      end
      chk_idle("R4 idle after done");
    end else begin
      start_i = 1'b0;
      chk(err_o == 1, "R6 err on illegal", err_o, 1);
      chk(beat_valid_o == 0, "R6 no beat on illegal", beat_valid_o, 0);
      @(negedge clk_i);
      chk(err_o == 0, "R6 err one cycle", err_o, 0);
      chk_idle("R6 idle after err");
    end
  endtask

  initial begin : watchdog
    repeat (200000) @(posedge clk_i);
    n_fail++; n_chk++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin : stim
    void'($urandom(32'd20240611));
    repeat (2) @(negedge clk_i);
    chk(beat_valid_o == 0 && done_o == 0 && err_o == 0 && beat_en_o == 0, "R1 reset outputs",
        {beat_valid_o, done_o, err_o, beat_en_o}, 0);
    chk_idle("R1 reset idle");
    rst_ni = 1'b1;
    @(negedge clk_i);
    chk_idle("R1 after release");
    chk(err_o == 0 && done_o == 0, "R1 no flags", {err_o, done_o}, 0);

    for (int o = 0; o < 4; o++)
      for (int s = 0; s < 8; s++)
        run_req(2'(o), 3'(s), 1'b1, 1'b0);
    run_req(2'd2, 3'd2, 1'b1, 1'b0);   // R6 edge: 2 dw at offset 2 legal
    run_req(2'd3, 3'd2, 1'b1, 1'b0);   // R6 edge: 2 dw at offset 3 refused
    run_req(2'd2, 3'd3, 1'b0, 1'b0);   // R6 edge: 3 dw at offset 2 refused
    run_req(2'd1, 3'd4, 1'b1, 1'b0);   // R6 edge: 4 dw at offset 1 refused
    run_req(2'd0, 3'd4, 1'b0, 1'b0);   // R7 read: no strobes
    run_req(2'd3, 3'd0, 1'b1, 1'b0);   // R9 sub-dw at offset 3
    run_req(2'd1, 3'd3, 1'b1, 1'b1);   // R8 start held during burst
    run_req(2'd0, 3'd1, 1'b1, 1'b1);   // R8

    for (int i = 0; i < 300; i++) begin
      int gap = $urandom_range(0, 2);
      repeat (gap) @(negedge clk_i);
      run_req(2'($urandom_range(0, 3)), 3'($urandom_range(0, 7)),
              1'($urandom_range(0, 1)), ($urandom_range(0, 7) == 0));
    end

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule